// File: doc/BRIEF.md
# Serial-Input Static LCD Segment Driver

This block drives a static, direct-drive liquid crystal panel with 32 segments. A host loads the segment pattern one bit at a time. It uses a data line and a shift clock. Each falling edge of the shift clock moves the pattern one place toward the top of a 32-bit register. When a load strobe is raised, the whole register is copied into a bank of 32 segment latches. While the strobe stays high, the latches are transparent, and the segments follow the register as it shifts.

Every segment output is its latched bit combined with a square-wave backplane. A segment is lit when it runs opposite in phase to the backplane. It is dark when it runs in phase with the backplane. The backplane is taken from one of two sources, chosen by a mode input. The first is an external phase input, re-registered on the system clock. The second is an internal divider of the system clock.

The bit that falls off the top of the register leaves on a serial output. A second copy of the block can therefore sit behind the first, so the pair drives 64 segments. The first device's backplane feeds the second device's phase input.

All inputs are sampled on the system clock `clk`. The shift clock is edge-detected against its value one system cycle earlier.

Top module: `lcd_static_drv`

## Requirements
- R1: A synchronous active-low reset clears the register, the latches and the backplane. After reset every segment equals the backplane, the backplane is 0 and the serial output is 0.
- R2: The register moves only in the system cycle after a 1-to-0 transition of `sclk_i` is seen. A rising edge of `sclk_i` or a steady level leaves it unchanged.
- R3: Each shift moves the register one place up and puts `sdata_i` into bit 0. After 32 shifts, the first bit sent is at `seg_o[31]` (segment 32) and the last bit sent is at `seg_o[0]` (segment 1).
- R4: While `load_i` is 0, the latches hold their value even while the register shifts.
- R5: While `load_i` is 1, the latches take the register value on every system clock. A single pulse therefore copies all 32 bits, and a held strobe makes the segments follow each shift one cycle later.
- R6: Each `seg_o[i]` is the backplane XOR latch bit i. A latched 1 drives the segment opposite the backplane, and a latched 0 drives it equal to the backplane.
- R7: With `int_phase_i` = 0, `bp_o` equals `phase_i` as sampled on the previous system clock.
- R8: With `int_phase_i` = 1, `bp_o` toggles every `BP_HALF` system cycles, and `phase_i` is ignored.
- R9: `sdata_o` is bit 31 of the register and changes only on a shift. When two devices are chained, 64 bits sent first-bit-first leave the first 32 bits in the downstream device.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sclk_i | input | 1 | Serial shift clock; the register shifts on its falling edge |
| sdata_i | input | 1 | Serial segment data |
| load_i | input | 1 | Latch strobe; the latches are transparent while it is high |
| phase_i | input | 1 | External backplane phase |
| int_phase_i | input | 1 | 1 selects the internal divider as the backplane source |
| seg_o | output | NSEG | Segment drive; bit i is segment i+1 |
| bp_o | output | 1 | Backplane drive |
| sdata_o | output | 1 | Serial data out for cascading |

## Verification
Two functions can fall in the same cycle:
- a shift of the register, and
- a latch update while the load strobe is held high.

The bench provokes this by holding the strobe and then dropping the shift clock. It judges the result in two steps:
- First, a rising shift-clock edge must leave every segment unchanged.
- Second, after the falling edge, the segments must show the shifted pattern exactly one system cycle after the register moves.

A second overlap is a backplane transition at the same time as the latch contents. It is checked by sampling the segments on both backplane levels in internal mode, and by chaining two instances across a full 64-bit transfer.

// File: rtl/lcd_drv_pkg.sv
package lcd_drv_pkg;

    // Source of the backplane square wave
    typedef enum logic {
        PH_EXTERNAL = 1'b0,
        PH_DIVIDER  = 1'b1
    } phase_src_e;

    // Default segment count of one device
    localparam int unsigned DEF_NSEG = 32;

    // Default half period for a 1 MHz system clock: about 64 Hz backplane
    localparam int unsigned DEF_BP_HALF = 7812;

endpackage

// File: rtl/lcd_drv_shift.sv
module lcd_drv_shift #(
    parameter int unsigned NSEG = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sclk_i,
    input  logic            sdata_i,
    output logic [NSEG-1:0] sr_o,
    output logic            sout_o
);

    typedef struct packed {
        logic            sclk_prev;
        logic [NSEG-1:0] sr;
    } shift_st_t;

    shift_st_t st_d, st_q;
    logic      fall;

    always_comb begin
        st_d           = st_q;
        fall           = st_q.sclk_prev & ~sclk_i;
        st_d.sclk_prev = sclk_i;
        if (fall) begin
            st_d.sr = {st_q.sr[NSEG-2:0], sdata_i};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sr_o   = st_q.sr;
    assign sout_o = st_q.sr[NSEG-1];

    // R2: no falling edge of the shift clock, no movement
    a_r2_hold_no_edge: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.sclk_prev && !sclk_i) |=> $stable(st_q.sr));

    // R3: a falling edge moves the register up by one and takes the data bit
    a_r3_shift_left: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.sclk_prev && !sclk_i) |=>
            (st_q.sr[0] == $past(sdata_i)) && (st_q.sr[NSEG-1:1] == $past(st_q.sr[NSEG-2:0])));

endmodule

// File: rtl/lcd_drv_latch.sv
module lcd_drv_latch #(
    parameter int unsigned NSEG = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic [NSEG-1:0] sr_i,
    output logic [NSEG-1:0] lat_o
);

    typedef struct packed {
        logic [NSEG-1:0] lat;
    } latch_st_t;

    latch_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.lat = sr_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lat_o = st_q.lat;

    // R4: strobe low keeps the latches frozen
    a_r4_hold_latch: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(st_q.lat));

    // R5: strobe high copies the register
    a_r5_transparent: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (st_q.lat == $past(sr_i)));

endmodule

// File: rtl/lcd_drv_bpgen.sv
module lcd_drv_bpgen
    import lcd_drv_pkg::*;
#(
    parameter int unsigned BP_HALF = DEF_BP_HALF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic int_phase_i,
    input  logic phase_i,
    output logic bp_o
);

    localparam int unsigned CW = (BP_HALF < 2) ? 1 : $clog2(BP_HALF);
    localparam logic [CW-1:0] CNT_LAST = CW'(BP_HALF - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          bp;
    } bp_st_t;

    bp_st_t     st_d, st_q;
    phase_src_e src;

    always_comb begin
        src  = phase_src_e'(int_phase_i);
        st_d = st_q;
        if (src == PH_EXTERNAL) begin
            st_d.cnt = '0;
            st_d.bp  = phase_i;
        end else if (st_q.cnt == CNT_LAST) begin
            st_d.cnt = '0;
            st_d.bp  = ~st_q.bp;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bp_o = st_q.bp;

    // R7: external mode follows the phase input one cycle later
    a_r7_ext_follow: assert property (@(posedge clk) disable iff (!rst_n)
        !int_phase_i |=> (st_q.bp == $past(phase_i)));

    // R8: in divider mode the backplane changes only at the end of a half period
    a_r8_div_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (int_phase_i && $past(int_phase_i) && (st_q.bp != $past(st_q.bp)))
            |-> ($past(st_q.cnt) == CNT_LAST));

    // R8: the divider count stays inside the half period
    a_r8_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_LAST);

endmodule

// File: rtl/lcd_static_drv.sv
module lcd_static_drv
    import lcd_drv_pkg::*;
#(
    parameter int unsigned NSEG    = DEF_NSEG,
    parameter int unsigned BP_HALF = DEF_BP_HALF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sclk_i,
    input  logic            sdata_i,
    input  logic            load_i,
    input  logic            phase_i,
    input  logic            int_phase_i,
    output logic [NSEG-1:0] seg_o,
    output logic            bp_o,
    output logic            sdata_o
);

    logic [NSEG-1:0] sr_w;
    logic [NSEG-1:0] lat_w;
    logic            bp_w;

    lcd_drv_shift #(.NSEG(NSEG)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_i  (sclk_i),
        .sdata_i (sdata_i),
        .sr_o    (sr_w),
        .sout_o  (sdata_o)
    );

    lcd_drv_latch #(.NSEG(NSEG)) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load_i),
        .sr_i   (sr_w),
        .lat_o  (lat_w)
    );

    lcd_drv_bpgen #(.BP_HALF(BP_HALF)) u_bpgen (
        .clk         (clk),
        .rst_n       (rst_n),
        .int_phase_i (int_phase_i),
        .phase_i     (phase_i),
        .bp_o        (bp_w)
    );

    // Per-segment polarity: a set latch bit runs opposite the backplane
    for (genvar i = 0; i < NSEG; i++) begin : g_seg
        assign seg_o[i] = lat_w[i] ^ bp_w;
    end

    assign bp_o = bp_w;

    // R1: first cycle after reset shows a blank panel and a quiet serial output
    a_r1_blank_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> ((seg_o == {NSEG{bp_o}}) && !sdata_o));

    // R9: the serial output only moves when a shift clock falls
    a_r9_sout_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !(u_shift.st_q.sclk_prev && !sclk_i) |=> $stable(sdata_o));

endmodule

// File: tb/lcd_static_drv_tb.sv
module lcd_static_drv_tb;

    localparam int CLK_P   = 10;
    localparam int NSEG    = 32;
    localparam int BP_HALF = 5;

    // {phase, pattern}
    localparam logic [32:0] VECS [0:5] = '{
        {1'b0, 32'h8000_0000},
        {1'b1, 32'h0000_0001},
        {1'b0, 32'hA5A5_0F0F},
        {1'b1, 32'hFFFF_FFFF},
        {1'b0, 32'h0000_0000},
        {1'b1, 32'h1234_5678}
    };

    logic clk = 1'b0;
    logic rst_n, sclk, sdata, load, phase, int_phase;
    logic [NSEG-1:0] seg_h, seg_t;
    logic bp_h, bp_t, sout_h, sout_t;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    lcd_static_drv #(.NSEG(NSEG), .BP_HALF(BP_HALF)) u_dut (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdata_i(sdata), .load_i(load),
        .phase_i(phase), .int_phase_i(int_phase),
        .seg_o(seg_h), .bp_o(bp_h), .sdata_o(sout_h)
    );

    lcd_static_drv #(.NSEG(NSEG), .BP_HALF(BP_HALF)) u_tail (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdata_i(sout_h), .load_i(load),
        .phase_i(bp_h), .int_phase_i(1'b0),
        .seg_o(seg_t), .bp_o(bp_t), .sdata_o(sout_t)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic shift_bit(input logic b);
        step(); sdata = b; sclk = 1'b1;
        step(); sclk = 1'b0;
        step();
    endtask

    task automatic shift_word(input logic [31:0] w);
        for (int k = 31; k >= 0; k--) shift_bit(w[k]);
    endtask

    task automatic pulse_load();
        step(); load = 1'b1;
        step(); step(); load = 1'b0;
        step();
    endtask

    initial begin
        logic [31:0] prev, w, hi, lo;
        logic ph, last;
        int n;
        rst_n = 1'b0; sclk = 1'b0; sdata = 1'b0; load = 1'b0; phase = 1'b0; int_phase = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk("R1 seg blank", seg_h, 32'h0);
        chk("R1 bp low", {31'b0, bp_h}, 32'h0);
        chk("R1 sdata_o low", {31'b0, sout_h}, 32'h0);

        // Vector table: shift with strobe low, then latch and check
        prev = 32'h0;
        for (int i = 0; i < 6; i++) begin
            ph = VECS[i][32];
            w  = VECS[i][31:0];
            step(); phase = ph;
            step(); step();
            chk("R7 bp follows phase", {31'b0, bp_h}, {31'b0, ph});
            shift_word(w);
            chk("R4 latches hold during shift", seg_h, prev ^ {32{ph}});
            chk("R9 sdata_o is top bit", {31'b0, sout_h}, {31'b0, w[31]});
            pulse_load();
            chk("R3/R5/R6 segments after load", seg_h, w ^ {32{ph}});
            prev = w;
        end

        // R2/R5: strobe held, rising edge ignored, falling edge followed
        w = prev;
        step(); load = 1'b1;
        step(); step();
        step(); sdata = 1'b1; sclk = 1'b1;
        step(); step(); step();
        chk("R2 rising edge ignored", seg_h, w ^ 32'hFFFF_FFFF);
        sclk = 1'b0;
        step(); step();
        chk("R5 transparent follows shift", seg_h, {w[30:0], 1'b1} ^ 32'hFFFF_FFFF);
        chk("R9 sdata_o after shift", {31'b0, sout_h}, {31'b0, w[30]});
        load = 1'b0;
        step();

        // R9: 64-bit transfer through a chain of two devices
        hi = 32'hC3A5_0F01;
        lo = 32'h5A5A_1234;
        shift_word(hi);
        shift_word(lo);
        pulse_load();
        step(); step();
        chk("R9 downstream holds first word", seg_t, hi ^ 32'hFFFF_FFFF);
        chk("R9 upstream holds second word", seg_h, lo ^ 32'hFFFF_FFFF);
        chk("R7 chained backplane", {31'b0, bp_t}, {31'b0, bp_h});

        // R8: internal divider
        step(); int_phase = 1'b1; phase = 1'b0;
        step();
        last = bp_h; n = 0;
        while (bp_h == last && n < 40) begin step(); n++; end
        last = bp_h; n = 0;
        while (bp_h == last && n < 40) begin step(); n++; end
        chk("R8 half period", n, BP_HALF);
        chk("R6 segments at one level", seg_h, lo ^ {32{bp_h}});
        last = bp_h; n = 0;
        while (bp_h == last && n < 40) begin step(); n++; end
        chk("R8 half period repeat", n, BP_HALF);
        chk("R6 segments at other level", seg_h, lo ^ {32{bp_h}});

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule